// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides whether a hart should take an interrupt in the current cycle and, if so, which one. It looks at the pending and enable vectors, the delegation mask, the current privilege level, and the two global interrupt-enable bits. Lines that are not delegated answer to the machine-level global enable. Delegated lines answer to the supervisor-level global enable. Each of these enables depends on the current privilege. Among the lines that survive gating, the one with the lowest index wins.

The result is a take strobe and an XLEN-wide cause word. The cause word carries the winning index in its low bits and has its top bit set to mark it as an interrupt. The trap logic consumes both outputs. The outputs are either purely combinational or registered once, chosen by a parameter. Storage of the trap state and the status registers belongs to the surrounding core.

Top module: `irq_delegate_select`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1. A line that is pending but not enabled is never taken.
- R2: A line whose delegation bit is 0 may be taken when the privilege is below machine (codes 0, 1 and 2). At machine privilege (code 3) it may be taken only when `m_gie` is 1.
- R3: A line whose delegation bit is 1 may be taken at user privilege (code 0). At supervisor privilege (code 1) it may be taken only when `s_gie` is 1. At codes 2 and 3 it is never taken.
- R4: When several gated candidates exist, delegated or not, the one with the lowest bit index is selected.
- R5: When a line is taken, `take_irq` is 1, `irq_cause[IDXW-1:0]` holds its index, `irq_cause[XLEN-1]` is 1, and all other cause bits are 0. This holds at the lowest index and at the highest index.
- R6: When no gated candidate exists, `take_irq` is 0 and `irq_cause` is all zeros.
- R7: With `REG_OUT`=1, both outputs show the result for the inputs present at the previous rising clock edge, and both are 0 during reset. With `REG_OUT`=0, the outputs follow the inputs combinationally.
- R8: `m_gie` has no effect on delegated lines, and `s_gie` has no effect on lines that are not delegated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT=1 |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line interrupt enables |
| irq_deleg | input | NUM_IRQ | Delegation mask; 1 routes the line to supervisor gating |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine-level global interrupt enable |
| s_gie | input | 1 | Supervisor-level global interrupt enable |
| take_irq | output | 1 | An interrupt is to be taken |
| irq_cause | output | XLEN | Cause word: interrupt flag in the top bit, index in the low bits |

## Verification
The bench builds the block with XLEN=32, NUM_IRQ=12 and REG_OUT=1. The 32-bit width places the interrupt flag at bit 31, where it is easy to see in the cause word. The 12 lines are not a power of two, so the highest index (11) and a 4-bit index field sit at an uneven boundary. Registered outputs make the one-cycle latency and the reset value of both outputs observable at the ports. Stimulus walks through all four privilege codes with each global enable both set and clear, using delegated and non-delegated lines alone and mixed.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  // Gate for lines that stay at machine level
  function automatic logic mach_gate_open(input logic [1:0] priv, input logic mie);
    return (priv != PRIV_MACH) || mie;
  endfunction

  // Gate for lines delegated to supervisor level
  function automatic logic sup_gate_open(input logic [1:0] priv, input logic sie);
    return (priv == PRIV_USER) || ((priv == PRIV_SUPER) && sie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_IRQ = 16
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [NUM_IRQ-1:0] deleg,
  input  logic [1:0]         priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               m_open,
  output logic               s_open,
  output logic [NUM_IRQ-1:0] cand,
  output logic [NUM_IRQ-1:0] gated
);
  import irq_sel_pkg::*;

  assign m_open = mach_gate_open(priv, m_gie);
  assign s_open = sup_gate_open(priv, s_gie);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign cand[i]  = pend[i] & en[i];
    assign gated[i] = cand[i] & (deleg[i] ? s_open : m_open);
  end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 16,
  parameter int IDXW    = 4
) (
  input  logic [NUM_IRQ-1:0] req,
  output logic               found,
  output logic [IDXW-1:0]    idx
);

  // Trailing-zero count: scan from the top so the lowest set bit is written last
  function automatic logic [IDXW-1:0] lowest_set(input logic [NUM_IRQ-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  assign found = |req;
  assign idx   = lowest_set(req);

endmodule

// File: rtl/irq_delegate_select.sv
module irq_delegate_select #(
  parameter int XLEN    = 64,
  parameter int NUM_IRQ = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_deleg,
  input  logic [1:0]         cur_priv,
  input  logic               m_gie,
  input  logic               s_gie,
  output logic               take_irq,
  output logic [XLEN-1:0]    irq_cause
);
  localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic               m_open, s_open;
  logic [NUM_IRQ-1:0] cand, gated;
  logic               win_found;
  logic [IDXW-1:0]    win_idx;
  logic               take_c;
  logic [XLEN-1:0]    cause_c;

  irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .pend (irq_pend),
    .en   (irq_en),
    .deleg(irq_deleg),
    .priv (cur_priv),
    .m_gie(m_gie),
    .s_gie(s_gie),
    .m_open(m_open),
    .s_open(s_open),
    .cand (cand),
    .gated(gated)
  );

  irq_pick #(.NUM_IRQ(NUM_IRQ), .IDXW(IDXW)) u_pick (
    .req  (gated),
    .found(win_found),
    .idx  (win_idx)
  );

  function automatic logic [XLEN-1:0] make_cause(input logic hit, input logic [IDXW-1:0] ix);
    logic [XLEN-1:0] c;
    c = '0;
    if (hit) begin
      c[IDXW-1:0] = ix;
      c[XLEN-1]   = 1'b1;
    end
    return c;
  endfunction

  assign take_c  = win_found;
  assign cause_c = make_cause(win_found, win_idx);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        take_irq  <= 1'b0;
        irq_cause <= '0;
      end else begin
        take_irq  <= take_c;
        irq_cause <= cause_c;
      end
    end

    // R7: registered outputs lag the selection by one edge
    a_r7_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (take_irq == $past(take_c)) && (irq_cause == $past(cause_c)));
  end else begin : g_comb
    assign take_irq  = take_c;
    assign irq_cause = cause_c;
  end

  // R1: winner is both pending and enabled
  a_r1_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |-> (irq_pend[win_idx] && irq_en[win_idx]));

  // R2: machine level with global enable clear takes no non-delegated line
  a_r2_mach_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv == 2'd3 && !m_gie) |-> ((gated & ~irq_deleg) == '0));

  // R3: delegated lines are closed above supervisor
  a_r3_deleg_blocked_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_priv[1]) |-> ((gated & irq_deleg) == '0));

  // R4: nothing below the winner survived gating
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |-> ((gated & ((NUM_IRQ'(1) << win_idx) - NUM_IRQ'(1))) == '0));

  // R5: cause carries the interrupt flag when taken
  a_r5_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |-> (cause_c[XLEN-1] && (cause_c[IDXW-1:0] == win_idx)));

  // R6: no candidate, no cause
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (!take_c && cause_c == '0));

endmodule

// File: tb/test_irq_delegate_select.sv
`timescale 1ns/1ps
module test_irq_delegate_select;
  localparam int XLEN = 32;
  localparam int NIRQ = 12;

  typedef struct {
    logic        take;
    logic [31:0] cause;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]      priv = 2'd0;
  logic            mg = 1'b0, sg = 1'b0;
  logic            take_irq;
  logic [XLEN-1:0] irq_cause;

  int   errors = 0, checks = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  irq_delegate_select #(.XLEN(XLEN), .NUM_IRQ(NIRQ), .REG_OUT(1'b1)) i_irq_delegate_select (
    .clk(clk), .rst_n(rst_n), .irq_pend(pend), .irq_en(en), .irq_deleg(deleg),
    .cur_priv(priv), .m_gie(mg), .s_gie(sg), .take_irq(take_irq), .irq_cause(irq_cause)
  );

  // Independent reference: per-line decision from the requirement text
  function automatic exp_t model(input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e,
                                 input logic [NIRQ-1:0] d, input logic [1:0] pv,
                                 input logic m, input logic s, input string tag);
    exp_t r;
    r.take = 1'b0; r.cause = 32'h0; r.tag = tag;
    for (int b = 0; b < NIRQ; b++) begin
      logic ok;
      if (!(p[b] && e[b])) continue;
      if (d[b]) ok = (pv == 2'd0) || (pv == 2'd1 && s);
      else      ok = (pv != 2'd3) || m;
      if (ok) begin
        r.take = 1'b1;
        r.cause = 32'h8000_0000 | b;
        break;
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e,
                       input logic [NIRQ-1:0] d, input logic [1:0] pv,
                       input logic m, input logic s, input string tag);
    @(negedge clk);
    pend = p; en = e; deleg = d; priv = pv; mg = m; sg = s;
    sb_q.push_back(model(p, e, d, pv, m, s, tag));
  endtask

  // Monitor: compare one result per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        checks++;
        if (take_irq !== x.take || irq_cause !== x.cause) begin
          errors++;
          $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                   x.tag, take_irq, irq_cause, x.take, x.cause);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (take_irq !== 1'b0 || irq_cause !== '0) begin
      errors++;
      $display("FAIL R7 reset: take=%0b cause=%h expected take=0 cause=0", take_irq, irq_cause);
    end
    @(negedge clk); rst_n = 1'b1;

    drive(12'h000, 12'h000, 12'h000, 2'd3, 1, 1, "R6 all idle");
    drive(12'h0F0, 12'h00F, 12'h000, 2'd3, 1, 1, "R1 pending not enabled");
    drive(12'h020, 12'h020, 12'h000, 2'd3, 0, 1, "R2 machine gie clear");
    drive(12'h020, 12'h020, 12'h000, 2'd3, 1, 0, "R2 machine gie set");
    drive(12'h020, 12'h020, 12'h000, 2'd1, 0, 0, "R2 supervisor open");
    drive(12'h020, 12'h020, 12'h000, 2'd2, 0, 0, "R2 code2 below machine");
    drive(12'h008, 12'h008, 12'h008, 2'd1, 1, 0, "R3 R8 supervisor sie clear");
    drive(12'h008, 12'h008, 12'h008, 2'd1, 0, 1, "R3 supervisor sie set");
    drive(12'h008, 12'h008, 12'h008, 2'd0, 0, 0, "R3 user open");
    drive(12'h008, 12'h008, 12'h008, 2'd3, 1, 1, "R3 machine blocks delegated");
    drive(12'h008, 12'h008, 12'h008, 2'd2, 1, 1, "R3 code2 blocks delegated");
    drive(12'h020, 12'h020, 12'h000, 2'd1, 0, 1, "R8 sie does not open machine line");
    drive(12'hA50, 12'hFFF, 12'h000, 2'd0, 0, 0, "R4 lowest of several");
    drive(12'h0A4, 12'hFFF, 12'h004, 2'd3, 1, 1, "R4 delegated blocked next wins");
    drive(12'h0A4, 12'hFFF, 12'h0A0, 2'd1, 0, 1, "R4 mixed lowest");
    drive(12'h800, 12'h800, 12'h000, 2'd3, 1, 0, "R5 top index");
    drive(12'h001, 12'h001, 12'h001, 2'd0, 0, 0, "R5 index zero");

    // R7: result must not appear before the next edge
    @(negedge clk);
    pend = '0; en = '0;
    sb_q.push_back(model('0, '0, '0, 2'd0, 0, 0, "R7 drained"));
    @(negedge clk);
    pend = 12'h002; en = 12'h002; deleg = '0; priv = 2'd3; mg = 1'b1;
    #1;
    checks++;
    if (take_irq !== 1'b0) begin
      errors++;
      $display("FAIL R7 early output: take=%0b expected take=0", take_irq);
    end
    sb_q.push_back(model(12'h002, 12'h002, '0, 2'd3, 1, 0, "R7 one cycle later"));

    drive(12'h000, 12'h000, 12'h000, 2'd0, 0, 0, "R6 back to idle");
    repeat (4) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule